// File: doc/BRIEF.md
# Configuration Request Retry Engine

This block sits on the requester side of a root-port configuration path. A local register interface hands it one configuration read or write at a time. The block packs the bus, device, function and register numbers into a downstream address word and issues the request. It then watches the completion status.

When a completion carries Configuration Request Retry Status (CRS), the block keeps the whole request. After a programmable gap it re-issues the request, until a programmable retry limit or a fixed cycle budget runs out. If the software-visibility enable is set, a CRS reply to a read of dword 0 (the Vendor ID) is not retried. The requester gets the synthetic value 0xFFFF0001 instead.

When the retries are exhausted, or a completion reports any other error, the request is turned into an all-ones failure and a sticky abort flag is set. Requests aimed at bus 0 go to the local root configuration space and never take the retry path. Read data is returned aligned to the requested byte size.

Top module: `cfg_retry_engine`

## Requirements
- R1: A request is accepted only when `busy_o` is low. `busy_o` stays high until the single-cycle `rsp_valid_o` pulse, and a request presented while busy is dropped: it produces no issue and no response.
- R2: For a nonzero bus, `dn_addr_o` is laid out as follows: bits 31:28 are zero, bits 27:20 are the bus, 19:15 the device, 14:12 the function, 11:2 the byte offset bits 11:2, bit 1 is zero and bit 0 is one.
- R3: A request to bus 0 raises `rc_valid_o` for one cycle and never raises `dn_valid_o`. The response carries `rc_rdata_i` with no error. `rc_addr_o` has the same layout as in R2 except that bit 0 is zero.
- R4: A completion with status 0 ends the request: a read returns the completion data, aligned as in R10, and `rsp_err_o` is 0.
- R5: A completion status that is nonzero and not 2 fails the request. A read returns all ones, masked to its size, `rsp_err_o` is 1 and `abort_o` is set.
- R6: With `sv_en_i` set, a status-2 (CRS) completion to a read whose offset bits 11:2 are zero is not retried. It returns 0xFFFF0001 with `rsp_err_o` 0, whatever the retry limit.
- R7: Every other CRS completion re-issues the same address, byte enables, write flag and write data. The new `dn_valid_o` pulse comes `retry_gap_i`+2 cycles after the cycle that carried the CRS completion.
- R8: At most `retry_limit_i` re-issues are made. A CRS completion that arrives when the limit has been used up fails the request as in R5, so a limit of 0 fails on the first CRS.
- R9: A CRS completion that arrives once `BUDGET_CYC` or more cycles have passed since acceptance fails the request as in R5, even if retries remain.
- R10: `req_size_i` is encoded 0 for one byte, 1 for two bytes and 2 for four bytes. For sizes 0 and 1 the read dword is shifted right by 8 times offset bits 1:0 and masked to the size. Four-byte reads are not shifted. Writes return 0.
- R11: A non-CRS completion returns its real data unchanged, even when `sv_en_i` is set and the data equals 0xFFFF0001.
- R12: `dn_be_o` is 4'b0001 shifted left by offset bits 1:0 for size 0, 4'b0011 shifted likewise for size 1, and 4'b1111 for size 2.
- R13: `abort_o` stays set across later successful requests until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe |
| req_write_i | input | 1 | 1 for write, 0 for read |
| req_bus_i | input | 8 | Target bus number |
| req_dev_i | input | 5 | Target device number |
| req_func_i | input | 3 | Target function number |
| req_off_i | input | 12 | Byte offset into configuration space |
| req_size_i | input | 2 | Access size code (R10) |
| req_wdata_i | input | 32 | Write data |
| busy_o | output | 1 | A request is in flight |
| sv_en_i | input | 1 | Software-visibility enable for dword-0 reads |
| retry_limit_i | input | LIM_W | Maximum number of re-issues |
| retry_gap_i | input | GAP_W | Gap before a re-issue, in cycles |
| dn_valid_o | output | 1 | Downstream issue pulse |
| dn_write_o | output | 1 | Downstream write flag |
| dn_addr_o | output | 32 | Packed downstream address |
| dn_be_o | output | 4 | Byte enables |
| dn_wdata_o | output | 32 | Downstream write data |
| cpl_valid_i | input | 1 | Completion strobe |
| cpl_status_i | input | 3 | Completion status: 0 success, 2 CRS |
| cpl_data_i | input | 32 | Completion read data |
| rc_valid_o | output | 1 | Local root-space access pulse |
| rc_write_o | output | 1 | Local write flag |
| rc_addr_o | output | 32 | Local address word |
| rc_be_o | output | 4 | Local byte enables |
| rc_wdata_o | output | 32 | Local write data |
| rc_ack_i | input | 1 | Local access done |
| rc_rdata_i | input | 32 | Local read data |
| rsp_valid_o | output | 1 | Final response pulse |
| rsp_data_o | output | 32 | Aligned read data |
| rsp_err_o | output | 1 | The request failed |
| abort_o | output | 1 | Sticky failure flag |

## Verification
The visibility rule and the retry limit meet on one completion when a dword-0 read with `sv_en_i` set receives CRS while the limit is zero. The bench provokes this and requires 0xFFFF0001 with no error and a single issue, rather than a failure. The retry limit and the cycle budget race each other with a long gap and a generous limit, and the bench counts the issues to check that the budget ends the request first. A second request is also pulsed during a retry gap, and the monitor checks every downstream pulse against the request the bench expects, so a dropped request that leaked through would show up as a wrong address.

// File: rtl/cfg_retry_pkg.sv
package cfg_retry_pkg;
  localparam int unsigned DW = 32;
  localparam logic [2:0] CPL_OK  = 3'd0;
  localparam logic [2:0] CPL_CRS = 3'd2;
  localparam logic [DW-1:0] SV_WORD   = 32'hFFFF_0001;
  localparam logic [DW-1:0] FAIL_WORD = 32'hFFFF_FFFF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ISSUE, ST_WAIT, ST_GAP, ST_RC_ISSUE, ST_RC_WAIT, ST_RESP
  } state_e;

  typedef struct packed {
    logic          write;
    logic [7:0]    bus;
    logic [4:0]    dev;
    logic [2:0]    func;
    logic [11:0]   off;
    logic [1:0]    size;
    logic [DW-1:0] wdata;
  } req_t;
endpackage

// File: rtl/cfg_addr_pack.sv
module cfg_addr_pack
  import cfg_retry_pkg::*;
(
  input  req_t        req_i,
  output logic [31:0] addr_o,
  output logic [3:0]  be_o
);
  logic [3:0] base_be;

  assign addr_o = {4'b0, req_i.bus, req_i.dev, req_i.func, req_i.off[11:2],
                   1'b0, (req_i.bus != 8'd0)};

  always_comb begin
    case (req_i.size)
      2'd0:    base_be = 4'b0001;
      2'd1:    base_be = 4'b0011;
      default: base_be = 4'b1111;
    endcase
    if (req_i.size[1]) be_o = 4'b1111;
    else               be_o = base_be << req_i.off[1:0];
  end
endmodule

// File: rtl/cfg_rsp_align.sv
module cfg_rsp_align
  import cfg_retry_pkg::*;
(
  input  logic [DW-1:0] raw_i,
  input  logic [1:0]    size_i,
  input  logic [1:0]    lane_i,
  input  logic          write_i,
  output logic [DW-1:0] data_o
);
  logic [DW-1:0] shifted;

  always_comb begin
    shifted = raw_i >> {lane_i, 3'b000};
    if (write_i) data_o = '0;
    else begin
      case (size_i)
        2'd0:    data_o = {24'b0, shifted[7:0]};
        2'd1:    data_o = {16'b0, shifted[15:0]};
        default: data_o = raw_i;
      endcase
    end
  end
endmodule

// File: rtl/cfg_retry_ctrl.sv
module cfg_retry_ctrl
  import cfg_retry_pkg::*;
#(
  parameter int unsigned LIM_W      = 8,
  parameter int unsigned GAP_W      = 16,
  parameter int unsigned BUDGET_CYC = 50_000_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  req_t             req_i,
  input  logic             sv_en_i,
  input  logic [LIM_W-1:0] retry_limit_i,
  input  logic [GAP_W-1:0] retry_gap_i,
  input  logic             cpl_valid_i,
  input  logic [2:0]       cpl_status_i,
  input  logic [DW-1:0]    cpl_data_i,
  input  logic             rc_ack_i,
  input  logic [DW-1:0]    rc_rdata_i,
  output req_t             req_o,
  output logic             busy_o,
  output logic             dn_valid_o,
  output logic             rc_valid_o,
  output logic             rsp_valid_o,
  output logic [DW-1:0]    raw_o,
  output logic             err_o,
  output logic             abort_o
);
  localparam int unsigned EL_W = $clog2(BUDGET_CYC + 1);
  localparam logic [EL_W-1:0] BUDGET = EL_W'(BUDGET_CYC);

  state_e           state_q;
  req_t             req_q;
  logic [LIM_W-1:0] tries_q;
  logic [GAP_W-1:0] gap_q;
  logic [EL_W-1:0]  elapsed_q;
  logic [DW-1:0]    raw_q;
  logic             err_q, abort_q;
  logic             sv_hit, may_retry;

  assign sv_hit    = sv_en_i && !req_q.write && (req_q.off[11:2] == 10'd0);
  assign may_retry = (tries_q < retry_limit_i) && (elapsed_q < BUDGET);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      req_q     <= '0;
      tries_q   <= '0;
      gap_q     <= '0;
      elapsed_q <= '0;
      raw_q     <= '0;
      err_q     <= 1'b0;
      abort_q   <= 1'b0;
    end else begin
      if (state_q != ST_IDLE && elapsed_q < BUDGET) elapsed_q <= elapsed_q + 1'b1;
      case (state_q)
        ST_IDLE: if (req_valid_i) begin
          req_q     <= req_i;
          tries_q   <= '0;
          elapsed_q <= '0;
          err_q     <= 1'b0;
          raw_q     <= '0;
          state_q   <= (req_i.bus == 8'd0) ? ST_RC_ISSUE : ST_ISSUE;
        end
        ST_ISSUE:    state_q <= ST_WAIT;
        ST_RC_ISSUE: state_q <= ST_RC_WAIT;
        ST_RC_WAIT: if (rc_ack_i) begin
          raw_q   <= rc_rdata_i;
          state_q <= ST_RESP;
        end
        ST_WAIT: if (cpl_valid_i) begin
          if (cpl_status_i == CPL_OK) begin
            raw_q   <= cpl_data_i;
            state_q <= ST_RESP;
          end else if (cpl_status_i == CPL_CRS && sv_hit) begin
            raw_q   <= SV_WORD;
            state_q <= ST_RESP;
          end else if (cpl_status_i == CPL_CRS && may_retry) begin
            tries_q <= tries_q + 1'b1;
            gap_q   <= retry_gap_i;
            state_q <= ST_GAP;
          end else begin
            raw_q   <= FAIL_WORD;
            err_q   <= 1'b1;
            abort_q <= 1'b1;
            state_q <= ST_RESP;
          end
        end
        ST_GAP: begin
          if (gap_q == '0) state_q <= ST_ISSUE;
          else             gap_q   <= gap_q - 1'b1;
        end
        ST_RESP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_o       = req_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign dn_valid_o  = (state_q == ST_ISSUE);
  assign rc_valid_o  = (state_q == ST_RC_ISSUE);
  assign rsp_valid_o = (state_q == ST_RESP);
  assign raw_o       = raw_q;
  assign err_o       = err_q;
  assign abort_o     = abort_q;

  // R8: no re-issue beyond the programmed limit
  p_retry_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_valid_o |-> (tries_q <= retry_limit_i));
  // R7: an issue is a single-cycle pulse
  p_issue_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_valid_o |=> !dn_valid_o);
  // R1: response is one cycle and frees the block
  p_rsp_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> (!rsp_valid_o && !busy_o));
  // R13: abort never clears outside reset
  p_abort_sticky_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> abort_o);
endmodule

// File: rtl/cfg_retry_engine.sv
module cfg_retry_engine
  import cfg_retry_pkg::*;
#(
  parameter int unsigned LIM_W      = 8,
  parameter int unsigned GAP_W      = 16,
  parameter int unsigned BUDGET_CYC = 50_000_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic [7:0]       req_bus_i,
  input  logic [4:0]       req_dev_i,
  input  logic [2:0]       req_func_i,
  input  logic [11:0]      req_off_i,
  input  logic [1:0]       req_size_i,
  input  logic [31:0]      req_wdata_i,
  output logic             busy_o,
  input  logic             sv_en_i,
  input  logic [LIM_W-1:0] retry_limit_i,
  input  logic [GAP_W-1:0] retry_gap_i,
  output logic             dn_valid_o,
  output logic             dn_write_o,
  output logic [31:0]      dn_addr_o,
  output logic [3:0]       dn_be_o,
  output logic [31:0]      dn_wdata_o,
  input  logic             cpl_valid_i,
  input  logic [2:0]       cpl_status_i,
  input  logic [31:0]      cpl_data_i,
  output logic             rc_valid_o,
  output logic             rc_write_o,
  output logic [31:0]      rc_addr_o,
  output logic [3:0]       rc_be_o,
  output logic [31:0]      rc_wdata_o,
  input  logic             rc_ack_i,
  input  logic [31:0]      rc_rdata_i,
  output logic             rsp_valid_o,
  output logic [31:0]      rsp_data_o,
  output logic             rsp_err_o,
  output logic             abort_o
);
  req_t        req_in, req_cur;
  logic [31:0] raw, addr;
  logic [3:0]  be;

  assign req_in = '{write: req_write_i, bus: req_bus_i, dev: req_dev_i,
                    func: req_func_i, off: req_off_i, size: req_size_i,
                    wdata: req_wdata_i};

  cfg_retry_ctrl #(.LIM_W(LIM_W), .GAP_W(GAP_W), .BUDGET_CYC(BUDGET_CYC)) u_ctrl (
    .clk_i, .rst_ni,
    .req_valid_i, .req_i(req_in),
    .sv_en_i, .retry_limit_i, .retry_gap_i,
    .cpl_valid_i, .cpl_status_i, .cpl_data_i,
    .rc_ack_i, .rc_rdata_i,
    .req_o(req_cur), .busy_o, .dn_valid_o, .rc_valid_o, .rsp_valid_o,
    .raw_o(raw), .err_o(rsp_err_o), .abort_o
  );

  cfg_addr_pack u_pack (.req_i(req_cur), .addr_o(addr), .be_o(be));

  cfg_rsp_align u_align (
    .raw_i(raw), .size_i(req_cur.size), .lane_i(req_cur.off[1:0]),
    .write_i(req_cur.write), .data_o(rsp_data_o)
  );

  assign dn_write_o = req_cur.write;
  assign dn_addr_o  = addr;
  assign dn_be_o    = be;
  assign dn_wdata_o = req_cur.wdata;
  assign rc_write_o = req_cur.write;
  assign rc_addr_o  = addr;
  assign rc_be_o    = be;
  assign rc_wdata_o = req_cur.wdata;

  // R7: the stored request stays put for the whole transaction
  p_addr_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(dn_addr_o) && $stable(dn_wdata_o)));
  // R5: a failed response is accompanied by the sticky flag
  p_err_abort_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_err_o) |-> abort_o);
  // R3: downstream accesses always carry the downstream type bit
  p_dn_type_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_valid_o |-> (dn_addr_o[0] && !rc_valid_o));
endmodule

// File: tb/tb_cfg_retry_engine.sv
module tb_cfg_retry_engine;
  localparam int BUDGET = 45;

  logic clk_i = 0, rst_ni = 0;
  logic req_valid_i = 0, req_write_i = 0;
  logic [7:0] req_bus_i = 0;
  logic [4:0] req_dev_i = 0;
  logic [2:0] req_func_i = 0;
  logic [11:0] req_off_i = 0;
  logic [1:0] req_size_i = 0;
  logic [31:0] req_wdata_i = 0;
  logic busy_o, sv_en_i = 0;
  logic [7:0] retry_limit_i = 0;
  logic [15:0] retry_gap_i = 0;
  logic dn_valid_o, dn_write_o;
  logic [31:0] dn_addr_o, dn_wdata_o;
  logic [3:0] dn_be_o;
  logic cpl_valid_i = 0;
  logic [2:0] cpl_status_i = 0;
  logic [31:0] cpl_data_i = 0;
  logic rc_valid_o, rc_write_o;
  logic [31:0] rc_addr_o, rc_wdata_o;
  logic [3:0] rc_be_o;
  logic rc_ack_i = 0;
  logic [31:0] rc_rdata_i = 0;
  logic rsp_valid_o, rsp_err_o, abort_o;
  logic [31:0] rsp_data_o;

  cfg_retry_engine #(.LIM_W(8), .GAP_W(16), .BUDGET_CYC(BUDGET)) dut (.*);

  always #5 clk_i = ~clk_i;

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // reference expectation for the current request
  logic [31:0] exp_addr, exp_wdata; logic [3:0] exp_be; logic exp_write;
  int ep_crs_left = 0; logic [2:0] ep_status = 0; logic [31:0] ep_data = 0;
  logic [31:0] rc_data = 0;
  bit cpl_pend = 0, rc_pend = 0, gap_chk = 0;
  int issue_cnt = 0, rc_cnt = 0, rsp_cnt = 0, last_crs_cyc = 0;
  bit got = 0; logic [31:0] got_data; logic got_err;

  // endpoint, local space and per-clock monitor
  always @(negedge clk_i) begin
    cpl_valid_i = 0; rc_ack_i = 0;
    if (cpl_pend) begin
      cpl_pend = 0;
      cpl_valid_i = 1;
      cpl_data_i = ep_data;
      if (ep_crs_left != 0) begin
        cpl_status_i = 3'd2;
        if (ep_crs_left > 0) ep_crs_left--;
        last_crs_cyc = cyc;
      end else cpl_status_i = ep_status;
    end
    if (rc_pend) begin rc_pend = 0; rc_ack_i = 1; rc_rdata_i = rc_data; end
    if (dn_valid_o) begin
      issue_cnt++;
      chk(dn_addr_o == exp_addr, "R2 dn_addr", dn_addr_o, exp_addr);
      chk(dn_be_o == exp_be, "R12 dn_be", {28'b0, dn_be_o}, {28'b0, exp_be});
      chk(dn_write_o == exp_write, "R7 dn_write", {31'b0, dn_write_o}, {31'b0, exp_write});
      if (exp_write) chk(dn_wdata_o == exp_wdata, "R7 dn_wdata", dn_wdata_o, exp_wdata);
      if (gap_chk && issue_cnt > 1)
        chk(cyc - last_crs_cyc == int'(retry_gap_i) + 2, "R7 gap", cyc - last_crs_cyc, int'(retry_gap_i) + 2);
      cpl_pend = 1;
    end
    if (rc_valid_o) begin rc_cnt++; rc_pend = 1; end
    if (rsp_valid_o) begin
      rsp_cnt++; got = 1; got_data = rsp_data_o; got_err = rsp_err_o;
    end
  end

  function automatic logic [31:0] pack(input logic [7:0] b, input logic [4:0] d,
                                       input logic [2:0] f, input logic [11:0] o);
    return {4'b0, b, d, f, o[11:2], 1'b0, (b != 0)};
  endfunction

  function automatic logic [3:0] mk_be(input logic [1:0] s, input logic [1:0] l);
    if (s == 0) return 4'b0001 << l;
    if (s == 1) return 4'b0011 << l;
    return 4'hF;
  endfunction

  task automatic send(input logic w, input logic [7:0] b, input logic [4:0] d,
                      input logic [2:0] f, input logic [11:0] o, input logic [1:0] s,
                      input logic [31:0] wd);
    exp_addr = pack(b, d, f, o); exp_be = mk_be(s, o[1:0]);
    exp_write = w; exp_wdata = wd;
    issue_cnt = 0; rc_cnt = 0; rsp_cnt = 0; got = 0;
    @(negedge clk_i);
    req_valid_i = 1; req_write_i = w; req_bus_i = b; req_dev_i = d;
    req_func_i = f; req_off_i = o; req_size_i = s; req_wdata_i = wd;
    @(negedge clk_i);
    req_valid_i = 0;
  endtask

  task automatic wait_rsp(input string tag);
    int n = 0;
    while (!got && n < 2000) begin @(negedge clk_i); n++; end
    if (!got) chk(0, {tag, " no response"}, 0, 1);
    @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !dn_valid_o && !rsp_valid_o && !abort_o, "R1 reset", {28'b0, busy_o, dn_valid_o, rsp_valid_o, abort_o}, 0);
    rst_ni = 1;
    retry_limit_i = 4; retry_gap_i = 3;

    // R4 R2 R12: plain 4-byte read
    ep_crs_left = 0; ep_status = 0; ep_data = 32'h1234_5678;
    send(0, 8'd3, 5'd5, 3'd2, 12'h124, 2'd2, 0); wait_rsp("R4");
    chk(got_data == 32'h1234_5678 && !got_err, "R4 data", got_data, 32'h1234_5678);
    chk(issue_cnt == 1, "R4 issues", issue_cnt, 1);

    // R10: 2-byte at lane 2, 1-byte at lane 3
    ep_data = 32'hAABB_CCDD;
    send(0, 8'd1, 5'd0, 3'd1, 12'h00A, 2'd1, 0); wait_rsp("R10");
    chk(got_data == 32'h0000_AABB, "R10 half", got_data, 32'h0000_AABB);
    send(0, 8'd1, 5'd31, 3'd7, 12'hFF3, 2'd0, 0); wait_rsp("R10");
    chk(got_data == 32'h0000_00AA, "R10 byte", got_data, 32'h0000_00AA);

    // R5: ordinary failure status 1
    ep_status = 3'd1;
    send(0, 8'd2, 5'd1, 3'd0, 12'h010, 2'd2, 0); wait_rsp("R5");
    chk(got_data == 32'hFFFF_FFFF && got_err && abort_o, "R5 fail", got_data, 32'hFFFF_FFFF);

    // R13: abort survives a success
    ep_status = 0; ep_data = 32'h5;
    send(0, 8'd2, 5'd1, 3'd0, 12'h010, 2'd2, 0); wait_rsp("R13");
    chk(!got_err && abort_o, "R13 sticky", {30'b0, got_err, abort_o}, 1);

    // R6: visibility hit with limit 0 beats the limit
    sv_en_i = 1; retry_limit_i = 0; ep_crs_left = -1;
    send(0, 8'd4, 5'd2, 3'd0, 12'h000, 2'd2, 0); wait_rsp("R6");
    chk(got_data == 32'hFFFF_0001 && !got_err, "R6 sv data", got_data, 32'hFFFF_0001);
    chk(issue_cnt == 1, "R6 no retry", issue_cnt, 1);

    // R11: real 0xFFFF0001 passes, nonzero offset still retries
    retry_limit_i = 4; ep_crs_left = 0; ep_data = 32'hFFFF_0001;
    send(0, 8'd4, 5'd2, 3'd0, 12'h000, 2'd2, 0); wait_rsp("R11");
    chk(got_data == 32'hFFFF_0001 && !got_err, "R11 real", got_data, 32'hFFFF_0001);
    ep_crs_left = 1; ep_data = 32'h0000_8086;
    send(0, 8'd4, 5'd2, 3'd0, 12'h004, 2'd2, 0); wait_rsp("R11");
    chk(issue_cnt == 2 && got_data == 32'h8086, "R11 offset4 retried", issue_cnt, 2);
    sv_en_i = 0;

    // R7 R1: write retried twice with gap timing, stray request ignored
    gap_chk = 1; ep_crs_left = 2;
    send(1, 8'd9, 5'd3, 3'd4, 12'h0C5, 2'd0, 32'hCAFE_F00D);
    repeat (3) @(negedge clk_i);
    req_valid_i = 1; req_bus_i = 8'd77; req_off_i = 12'h400; @(negedge clk_i); req_valid_i = 0;
    wait_rsp("R7");
    chk(issue_cnt == 3 && !got_err && got_data == 0, "R7 write retried", issue_cnt, 3);
    repeat (5) @(negedge clk_i);
    chk(rsp_cnt == 1 && issue_cnt == 3 && !busy_o, "R1 stray dropped", rsp_cnt, 1);
    gap_chk = 0;

    // R8: limit 2 then limit 0
    retry_limit_i = 2; retry_gap_i = 1; ep_crs_left = -1;
    send(0, 8'd5, 5'd0, 3'd0, 12'h008, 2'd1, 0); wait_rsp("R8");
    chk(issue_cnt == 3 && got_err && got_data == 32'h0000_FFFF, "R8 limit2", issue_cnt, 3);
    retry_limit_i = 0;
    send(1, 8'd5, 5'd0, 3'd0, 12'h008, 2'd2, 32'h1); wait_rsp("R8");
    chk(issue_cnt == 1 && got_err, "R8 limit0", issue_cnt, 1);

    // R9: budget ends the request before the limit
    retry_limit_i = 15; retry_gap_i = 10;
    send(0, 8'd6, 5'd1, 3'd1, 12'h020, 2'd2, 0); wait_rsp("R9");
    chk(issue_cnt == 5 && got_err && got_data == 32'hFFFF_FFFF, "R9 budget", issue_cnt, 5);

    // R3: bus 0 goes local
    ep_crs_left = -1; rc_data = 32'h0BAD_BEEF;
    send(0, 8'd0, 5'd0, 3'd0, 12'h008, 2'd2, 0); wait_rsp("R3");
    chk(rc_cnt == 1 && issue_cnt == 0, "R3 path", rc_cnt, 1);
    chk(got_data == 32'h0BAD_BEEF && !got_err, "R3 data", got_data, 32'h0BAD_BEEF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule